// File: doc/BRIEF.md
# Prioritized Interrupt Controller Core

This block collects a parameterized set of level-sensitive interrupt inputs and drives one interrupt line to a single processor. Software controls it through a 32-bit read/write bus that has two register windows. A window-select bit picks between them. The global window holds the global control word, the index-based enable set and clear registers, and one control word per source. The processor window holds the task-priority threshold, the acknowledge register, the index-based mask set and clear registers, and a doorbell cause word.

A source is eligible when four things are true: its input is high, it is enabled, it is unmasked, and its 4-bit priority is strictly greater than the threshold. The interrupt line is a combinational OR over all eligible sources. Reading the acknowledge register returns the number of the winning source. The winner is chosen either by priority or by lowest number. When no source is eligible, the read returns the reserved code 1023. The acknowledge read has no side effect: the sources are level-sensitive and there is no completion handshake. Every read returns its data one cycle after the read strobe.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset, every source is disabled and masked, every priority and the threshold are 0, priority selection is off, and `cpu_irq` is low even when every input is high.
- R2: The global control word (window 0, offset 0x000) reads the implemented source count in bits [11:2] and the priority-selection flag in bit 0. Writing bit 0 sets or clears that flag.
- R3: Writing a source number to window 0 offset 0x030 sets that source's enable. Writing a source number to offset 0x034 clears it. The enable is visible as bit 28 of the source control word.
- R4: The control word of source n (window 0, offset 0x100 + 4n) holds the priority in bits [27:24] and the enable in bit 28. A write to it loads both fields, and a read returns them with all other bits 0.
- R5: Writing a source number to window 1 offset 0x048 masks that source. Writing a source number to offset 0x04C unmasks it. A masked source never raises `cpu_irq` and is never acknowledged.
- R6: The threshold sits in bits [31:28] of window 1 offset 0x040 and reads back as written. A source is eligible only when its priority is strictly greater than the threshold.
- R7: `cpu_irq` is high in the same cycle as any source is eligible, and low otherwise. This includes when an input drops.
- R8: With priority selection on, an acknowledge read (window 1, offset 0x044) returns the number of the eligible source with the highest priority in bits [9:0]. Ties go to the lowest source number.
- R9: With priority selection off, the acknowledge read returns the lowest-numbered eligible source, whatever its priority.
- R10: An acknowledge read with no eligible source returns 1023.
- R11: Set and clear writes that name a source number at or above the implemented count are ignored. Control words of unimplemented sources read as 0, and writes to them are ignored.
- R12: The doorbell cause word (window 1, offset 0x008) accepts a write of 0 and reads as 0.
- R13: Read data appears on `bus_rdata` in the cycle after the `bus_rd` strobe, and holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_win | input | 1 | Window select: 0 global, 1 processor |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 13 | Byte offset within the selected window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid one cycle after `bus_rd` |
| irq_src | input | NUM_SRC | Level interrupt inputs |
| cpu_irq | output | 1 | Interrupt request to the processor |

## Verification
A wrong enable, mask or priority bit shows up on `cpu_irq` in the same cycle as the write that set it takes effect. It also shows on the next acknowledge read, which returns data one cycle later: either the wrong winner or a spurious 1023. A control word that was decoded to the wrong source shows on readback of both that source and the source it aliases to. This is why the bench reads back neighbouring and out-of-range indices right after every set, clear and control-word write.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
   localparam int IDX_W  = 10;
   localparam int ADDR_W = 13;
   localparam logic [IDX_W-1:0] SPURIOUS_ID = 10'd1023;

   // global window
   localparam logic [ADDR_W-1:0] OFF_GCTRL   = 13'h000;
   localparam logic [ADDR_W-1:0] OFF_EN_SET  = 13'h030;
   localparam logic [ADDR_W-1:0] OFF_EN_CLR  = 13'h034;
   localparam logic [ADDR_W-1:0] OFF_SRC_BASE = 13'h100;
   // processor window
   localparam logic [ADDR_W-1:0] OFF_DBELL   = 13'h008;
   localparam logic [ADDR_W-1:0] OFF_THRESH  = 13'h040;
   localparam logic [ADDR_W-1:0] OFF_ACK     = 13'h044;
   localparam logic [ADDR_W-1:0] OFF_MSK_SET = 13'h048;
   localparam logic [ADDR_W-1:0] OFF_MSK_CLR = 13'h04C;

   localparam int PRIO_LSB   = 24;
   localparam int SRC_EN_BIT = 28;
   localparam int THR_LSB    = 28;

   typedef enum logic {WIN_GLOBAL = 1'b0, WIN_CPU = 1'b1} win_e;
endpackage

// File: rtl/irqc_src_regs.sv
module irqc_src_regs
   import irqc_pkg::*;
#(
   parameter int NUM_SRC = 32,
   parameter int PRIO_W  = 4
) (
   input  logic                             clk,
   input  logic                             rst_n,
   input  logic                             en_set,
   input  logic                             en_clr,
   input  logic                             msk_set,
   input  logic                             msk_clr,
   input  logic [IDX_W-1:0]                 op_idx,
   input  logic                             cfg_we,
   input  logic [IDX_W-1:0]                 cfg_idx,
   input  logic [PRIO_W-1:0]                cfg_prio,
   input  logic                             cfg_en,
   output logic [NUM_SRC-1:0]               en_q,
   output logic [NUM_SRC-1:0]               msk_q,
   output logic [NUM_SRC-1:0][PRIO_W-1:0]   prio_q
);
   for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
      localparam logic [IDX_W-1:0] MY_ID = IDX_W'(g);
      logic hit_op, hit_cfg;
      assign hit_op  = (op_idx == MY_ID);
      assign hit_cfg = cfg_we && (cfg_idx == MY_ID);

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            en_q[g]   <= 1'b0;
            msk_q[g]  <= 1'b1;
            prio_q[g] <= '0;
         end else begin
            if (hit_cfg) begin
               en_q[g]   <= cfg_en;
               prio_q[g] <= cfg_prio;
            end else if (hit_op && en_set) begin
               en_q[g] <= 1'b1;
            end else if (hit_op && en_clr) begin
               en_q[g] <= 1'b0;
            end
            if (hit_op && msk_set)      msk_q[g] <= 1'b1;
            else if (hit_op && msk_clr) msk_q[g] <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/irqc_arbiter.sv
module irqc_arbiter
   import irqc_pkg::*;
#(
   parameter int NUM_SRC = 32,
   parameter int PRIO_W  = 4
) (
   input  logic [NUM_SRC-1:0]             irq_src,
   input  logic [NUM_SRC-1:0]             en_q,
   input  logic [NUM_SRC-1:0]             msk_q,
   input  logic [NUM_SRC-1:0][PRIO_W-1:0] prio_q,
   input  logic [PRIO_W-1:0]              thresh,
   input  logic                           prio_mode,
   output logic                           any_elig,
   output logic [IDX_W-1:0]               win_id
);
   logic [NUM_SRC-1:0] elig;

   for (genvar g = 0; g < NUM_SRC; g++) begin : g_elig
      assign elig[g] = irq_src[g] && en_q[g] && !msk_q[g] && (prio_q[g] > thresh);
   end

   assign any_elig = |elig;

   // Scan from the top down so the lowest index survives any tie.
   always_comb begin
      logic              found;
      logic [PRIO_W-1:0] best_p;
      found  = 1'b0;
      best_p = '0;
      win_id = SPURIOUS_ID;
      for (int i = NUM_SRC - 1; i >= 0; i--) begin
         if (elig[i] && (!found || !prio_mode || (prio_q[i] >= best_p))) begin
            found  = 1'b1;
            best_p = prio_q[i];
            win_id = IDX_W'(i);
         end
      end
   end
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
   import irqc_pkg::*;
#(
   parameter int NUM_SRC = 32,
   parameter int PRIO_W  = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               bus_win,
   input  logic               bus_wr,
   input  logic               bus_rd,
   input  logic [12:0]        bus_addr,
   input  logic [31:0]        bus_wdata,
   output logic [31:0]        bus_rdata,
   input  logic [NUM_SRC-1:0] irq_src,
   output logic               cpu_irq
);
   localparam logic [31:0] SRC_LIMIT = 32'(NUM_SRC);

   if (NUM_SRC < 1 || NUM_SRC > 1023) begin : g_bad_num
      $error("prio_irq_ctrl: NUM_SRC must lie in 1..1023");
   end
   if (PRIO_W < 1 || PRIO_W > 4) begin : g_bad_prio
      $error("prio_irq_ctrl: PRIO_W must lie in 1..4");
   end

   logic                           prio_mode_q;
   logic [PRIO_W-1:0]              thresh_q;
   logic [NUM_SRC-1:0]             en_q, msk_q;
   logic [NUM_SRC-1:0][PRIO_W-1:0] prio_q;
   logic                           any_elig;
   logic [IDX_W-1:0]               win_id;

   // address decode
   logic        is_glob, is_cpu, idx_ok, src_hit;
   logic [12:0] src_off;
   logic [10:0] src_n;
   logic [IDX_W-1:0] op_idx, cfg_idx;

   assign is_glob = (win_e'(bus_win) == WIN_GLOBAL);
   assign is_cpu  = (win_e'(bus_win) == WIN_CPU);
   assign idx_ok  = (bus_wdata < SRC_LIMIT);
   assign op_idx  = bus_wdata[IDX_W-1:0];
   assign src_off = bus_addr - OFF_SRC_BASE;
   assign src_n   = src_off[12:2];
   assign src_hit = is_glob && (bus_addr >= OFF_SRC_BASE) && (bus_addr[1:0] == 2'b00)
                    && (src_n < 11'(NUM_SRC));
   assign cfg_idx = src_n[IDX_W-1:0];

   logic en_set, en_clr, msk_set, msk_clr, cfg_we;
   assign en_set  = bus_wr && is_glob && (bus_addr == OFF_EN_SET)  && idx_ok;
   assign en_clr  = bus_wr && is_glob && (bus_addr == OFF_EN_CLR)  && idx_ok;
   assign msk_set = bus_wr && is_cpu  && (bus_addr == OFF_MSK_SET) && idx_ok;
   assign msk_clr = bus_wr && is_cpu  && (bus_addr == OFF_MSK_CLR) && idx_ok;
   assign cfg_we  = bus_wr && src_hit;

   irqc_src_regs #(.NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W)) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .en_set   (en_set),
      .en_clr   (en_clr),
      .msk_set  (msk_set),
      .msk_clr  (msk_clr),
      .op_idx   (op_idx),
      .cfg_we   (cfg_we),
      .cfg_idx  (cfg_idx),
      .cfg_prio (bus_wdata[PRIO_LSB +: PRIO_W]),
      .cfg_en   (bus_wdata[SRC_EN_BIT]),
      .en_q     (en_q),
      .msk_q    (msk_q),
      .prio_q   (prio_q)
   );

   irqc_arbiter #(.NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W)) u_arb (
      .irq_src   (irq_src),
      .en_q      (en_q),
      .msk_q     (msk_q),
      .prio_q    (prio_q),
      .thresh    (thresh_q),
      .prio_mode (prio_mode_q),
      .any_elig  (any_elig),
      .win_id    (win_id)
   );

   assign cpu_irq = any_elig;

   // global control and threshold
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         prio_mode_q <= 1'b0;
         thresh_q    <= '0;
      end else if (bus_wr) begin
         if (is_glob && bus_addr == OFF_GCTRL) prio_mode_q <= bus_wdata[0];
         if (is_cpu && bus_addr == OFF_THRESH) thresh_q <= bus_wdata[THR_LSB +: PRIO_W];
      end
   end

   // read mux
   logic [31:0] rd_mux;
   always_comb begin
      rd_mux = '0;
      if (is_glob) begin
         if (bus_addr == OFF_GCTRL) begin
            rd_mux[11:2] = IDX_W'(NUM_SRC);
            rd_mux[0]    = prio_mode_q;
         end else if (src_hit) begin
            rd_mux[SRC_EN_BIT]          = en_q[cfg_idx];
            rd_mux[PRIO_LSB +: PRIO_W]  = prio_q[cfg_idx];
         end
      end else begin
         if (bus_addr == OFF_THRESH) rd_mux[THR_LSB +: PRIO_W] = thresh_q;
         else if (bus_addr == OFF_ACK) rd_mux[IDX_W-1:0] = win_id;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)      bus_rdata <= '0;
      else if (bus_rd) bus_rdata <= rd_mux;
   end
endmodule

// File: rtl/irqc_checker.sv
module irqc_checker
   import irqc_pkg::*;
#(
   parameter int NUM_SRC = 32,
   parameter int PRIO_W  = 4
) (
   input logic               clk,
   input logic               rst_n,
   input logic               bus_win,
   input logic               bus_rd,
   input logic [12:0]        bus_addr,
   input logic [31:0]        bus_rdata,
   input logic [NUM_SRC-1:0] irq_src,
   input logic [NUM_SRC-1:0] en_q,
   input logic [NUM_SRC-1:0] msk_q,
   input logic [PRIO_W-1:0]  thresh_q,
   input logic               cpu_irq
);
   logic ack_rd;
   assign ack_rd = bus_rd && bus_win && (bus_addr == OFF_ACK);

   p_spurious_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_rd && !cpu_irq) |=> (bus_rdata == 32'(SPURIOUS_ID)));

   p_ack_in_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_rd && cpu_irq) |=> (bus_rdata < 32'(NUM_SRC)));

   p_irq_needs_src_r7: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_irq |-> ((irq_src & en_q & ~msk_q) != '0));

   p_top_thresh_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (&thresh_q) |-> !cpu_irq);

   p_rdata_hold_r13: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_rd |=> $stable(bus_rdata));
endmodule

bind prio_irq_ctrl irqc_checker #(.NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_win   (bus_win),
   .bus_rd    (bus_rd),
   .bus_addr  (bus_addr),
   .bus_rdata (bus_rdata),
   .irq_src   (irq_src),
   .en_q      (en_q),
   .msk_q     (msk_q),
   .thresh_q  (thresh_q),
   .cpu_irq   (cpu_irq)
);

// File: tb/prio_irq_ctrl_tb.sv
module prio_irq_ctrl_tb;
   localparam int N = 32;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_win = 1'b0, bus_wr = 1'b0, bus_rd = 1'b0;
   logic [12:0] bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [N-1:0] irq_src = '0;
   logic        cpu_irq;

   int n_checks = 0;
   int n_errors = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;   // 200 MHz

   prio_irq_ctrl #(.NUM_SRC(N), .PRIO_W(4)) u_dut (
      .clk(clk), .rst_n(rst_n), .bus_win(bus_win), .bus_wr(bus_wr), .bus_rd(bus_rd),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .irq_src(irq_src), .cpu_irq(cpu_irq)
   );

   typedef struct {
      logic [31:0] exp;
      string       tag;
   } sb_item_t;

   sb_item_t sb_q[$];
   logic     rd_seen = 1'b0;

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_errors++;
         $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
      end
   endtask

   // monitor: read data is due one cycle after the strobe (R13)
   always @(posedge clk) rd_seen <= bus_rd;
   always @(negedge clk) begin
      if (rd_seen) begin
         if (sb_q.size() == 0) check("R13 unexpected read data", 32'h1, 32'h0);
         else begin
            sb_item_t it;
            it = sb_q.pop_front();
            check(it.tag, bus_rdata, it.exp);
         end
      end
   end

   task automatic bus_write(input logic win, input logic [12:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_win = win; bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic bus_read(input logic win, input logic [12:0] a, input logic [31:0] exp,
                           input string tag);
      sb_item_t it;
      @(negedge clk);
      bus_win = win; bus_addr = a; bus_rd = 1'b1;
      it.exp = exp; it.tag = tag;
      sb_q.push_back(it);
      @(negedge clk);
      bus_rd = 1'b0;
   endtask

   function automatic logic [12:0] src_addr(input int n);
      return 13'(32'h100 + 4 * n);
   endfunction

   function automatic logic [31:0] src_word(input logic en, input logic [3:0] p);
      return {3'b000, en, p, 24'h0};
   endfunction

   task automatic check_irq(input string tag, input logic exp);
      #1;
      check(tag, {31'b0, cpu_irq}, {31'b0, exp});
   endtask

   initial begin : watchdog
      #(5ns * 20000);
      if (!done) begin
         n_errors++;
         n_checks++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1 / R2 reset state
      check("R1 reset rdata", bus_rdata, 32'h0);
      bus_read(0, 13'h000, 32'(N) << 2, "R2 control word after reset");
      bus_read(0, src_addr(5), 32'h0, "R1 source 5 word after reset");
      bus_read(1, 13'h040, 32'h0, "R1 threshold after reset");
      bus_read(1, 13'h044, 32'd1023, "R10 ack after reset");
      irq_src = '1;
      check_irq("R1 all inputs high, nothing enabled", 1'b0);

      bus_write(0, 13'h000, 32'h1);
      bus_read(0, 13'h000, (32'(N) << 2) | 32'h1, "R2 priority mode on");

      // source 3: prio 5, enabled through control word, still masked
      bus_write(0, src_addr(3), src_word(1'b1, 4'd5));
      bus_read(0, src_addr(3), 32'h1500_0000, "R4 source 3 word");
      check_irq("R5 masked source stays silent", 1'b0);
      bus_write(1, 13'h04C, 32'd3);
      check_irq("R7 irq after unmask", 1'b1);
      bus_read(1, 13'h044, 32'd3, "R8 single source ack");

      // source 7: prio 9, enable through set register
      bus_write(0, src_addr(7), src_word(1'b0, 4'd9));
      bus_write(0, 13'h030, 32'd7);
      bus_read(0, src_addr(7), 32'h1900_0000, "R3 enable set visible in bit 28");
      bus_write(1, 13'h04C, 32'd7);
      bus_read(1, 13'h044, 32'd7, "R8 higher priority wins");

      // source 2: prio 9 ties with 7
      bus_write(0, src_addr(2), src_word(1'b1, 4'd9));
      bus_write(1, 13'h04C, 32'd2);
      bus_read(1, 13'h044, 32'd2, "R8 tie to lowest number");

      // clear enable of 2
      bus_write(0, 13'h034, 32'd2);
      bus_read(0, src_addr(2), 32'h0900_0000, "R3 enable cleared");
      bus_write(0, 13'h000, 32'h0);
      bus_read(1, 13'h044, 32'd3, "R9 lowest eligible wins with priority off");
      bus_write(0, 13'h000, 32'h1);
      bus_read(1, 13'h044, 32'd7, "R8 priority mode restored");

      // threshold
      bus_write(1, 13'h040, 32'h9000_0000);
      check_irq("R6 threshold equal to top priority blocks", 1'b0);
      bus_read(1, 13'h044, 32'd1023, "R10 nothing above threshold");
      bus_write(1, 13'h040, 32'h8000_0000);
      bus_read(1, 13'h040, 32'h8000_0000, "R6 threshold readback");
      bus_read(1, 13'h044, 32'd7, "R6 only priority 9 above 8");
      bus_write(1, 13'h048, 32'd7);
      bus_read(1, 13'h044, 32'd1023, "R5 masked source not acknowledged");
      check_irq("R5 irq low after mask", 1'b0);

      // out of range
      bus_write(1, 13'h040, 32'h0);
      bus_write(0, 13'h034, 32'(N + 3));
      bus_read(0, src_addr(3), 32'h1500_0000, "R11 clear with index out of range ignored");
      bus_write(1, 13'h048, 32'(N + 3));
      bus_read(1, 13'h044, 32'd3, "R11 mask with index out of range ignored");
      bus_write(0, src_addr(N + 8), src_word(1'b1, 4'd7));
      bus_read(0, src_addr(N + 8), 32'h0, "R11 unimplemented word reads zero");
      bus_read(0, src_addr(8), 32'h0, "R11 no alias onto source 8");

      // doorbell
      bus_write(1, 13'h008, 32'h0);
      bus_read(1, 13'h008, 32'h0, "R12 doorbell reads zero");

      // input drop
      @(negedge clk);
      irq_src[3] = 1'b0;
      check_irq("R7 irq follows input drop", 1'b0);
      bus_read(1, 13'h044, 32'd1023, "R10 spurious after input drop");

      repeat (3) @(negedge clk);
      check("R13 scoreboard drained", 32'(sb_q.size()), 32'h0);
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
   end
endmodule